// File: doc/BRIEF.md
# Source Operand Resolver

This block turns the 9-bit source operand code of a shader instruction into the operand value used to execute it. One shared code space holds several kinds of source. Low codes name scalar registers. A few codes name special registers: the vector-carry pair, the execution mask pair and the memory register. One range holds built-in integer constants and another holds built-in floating-point constants. One code means that a literal dword follows the instruction word. The top codes name vector registers, and the block passes these on as an index only.

The decoder presents one operand request at a time with a valid/ready handshake. The request carries the code and four attributes:

- the register count of the operand;
- whether the instruction is a vector instruction;
- whether the three-operand encoding is in use;
- how a 64-bit literal is to be widened.

The block reads the scalar register file through two combinational read ports, one for each 32-bit half. When the code asks for a literal, the block requests the next instruction dword and presents nothing until that dword arrives. It also checks that multi-register scalar ranges start on a legal boundary and flags codes that name nothing.

Top module: `opnd_resolve`

## Requirements
- R1: A code below `NUM_SGPR` selects scalar register `code`, read at `rf_addr_lo`, as `out_value[31:0]`. For a multi-register operand (`in_cnt` = 1, 2 or 3, meaning 2, 4 or 8 registers), `out_value[63:32]` is the 32-bit word named by `code+1`. That word is zero when `code+1` names nothing. For a single register (`in_cnt` = 0), the upper half is zero.
- R2: Code 106 gives `vcc_val[31:0]`, 107 gives `vcc_val[63:32]`, 124 gives `m0_val`, 126 gives `exec_val[31:0]` and 127 gives `exec_val[63:32]`. The upper half follows the same `code+1` rule as R1.
- R3: Code 128 gives 0, codes 129..192 give 1..64, and codes 193..208 give -1..-16. A 64-bit operand receives the exact 64-bit value, sign-extended. A 32-bit operand has a zero upper half.
- R4: Codes 240..247 give 0.5, -0.5, 1.0, -1.0, 2.0, -2.0, 4.0, -4.0, and code 248 gives 1/(2*pi). The value is in single precision in the low half for a 32-bit operand and in double precision for a 64-bit operand.
- R5: After code 255 is accepted, `lit_req` is high and `in_ready` is low until the cycle in which `lit_valid` is high. `out_valid` rises in the next cycle.
- R6: The literal is widened as follows:
  - For a 32-bit operand, it is zero-extended.
  - For a 64-bit operand with `in_fp64` high, the literal forms the upper half and the lower half is zero.
  - Otherwise, a 64-bit operand is sign-extended when `in_signed` is high and zero-extended when it is low.
- R7: In a scalar instruction (`in_vec` low), `out_misalign` rises for a register code (R1/R2) with a 2-register range starting on an odd code, or with a 4- or 8-register range whose start is not a multiple of 4.
- R8: In a vector instruction, `out_misalign` rises for a register code whose range leaves its aligned group of 4 registers. An 8-register range therefore always leaves its group.
- R9: Codes 256..511 with `in_vop3` high raise `out_vreg`, give `out_vidx` = code-256 and give a zero value. With `in_vop3` low, these codes are illegal.
- R10: All other codes are illegal and raise `out_illegal` with a zero value. These are the scalar codes from `NUM_SGPR` to 103, codes 104, 105, 108..123 and 125, codes 209..239 and codes 249..254. At most one of `out_illegal`, `out_vreg` and `out_misalign` is high.
- R11: After reset, `in_ready` is high and both `out_valid` and `lit_req` are low. A non-literal request accepted at a clock edge produces `out_valid` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand request present |
| in_ready | output | 1 | Block can accept a request |
| in_code | input | 9 | Source operand code |
| in_cnt | input | 2 | Register count, log2 (0..3) |
| in_vec | input | 1 | Request belongs to a vector instruction |
| in_vop3 | input | 1 | Three-operand encoding in use |
| in_fp64 | input | 1 | Operand is double precision |
| in_signed | input | 1 | Sign-extend a 64-bit integer literal |
| rf_addr_lo | output | $clog2(NUM_SGPR) | Scalar file read address, low half |
| rf_addr_hi | output | $clog2(NUM_SGPR) | Scalar file read address, high half |
| rf_data_lo | input | 32 | Scalar file read data, low half |
| rf_data_hi | input | 32 | Scalar file read data, high half |
| vcc_val | input | 64 | Vector-carry register contents |
| exec_val | input | 64 | Execution mask contents |
| m0_val | input | 32 | Memory register contents |
| lit_req | output | 1 | Waiting for the trailing literal dword |
| lit_valid | input | 1 | Literal dword present |
| lit_data | input | 32 | Literal dword |
| out_valid | output | 1 | Resolved operand present (one cycle) |
| out_value | output | 64 | Resolved operand value |
| out_vreg | output | 1 | Operand is a vector register |
| out_vidx | output | 8 | Vector register index |
| out_illegal | output | 1 | Code names nothing in this context |
| out_misalign | output | 1 | Register range start is illegal |

## Verification
The bench builds the block with `NUM_SGPR` = 102. Codes 102 and 103 then become illegal, and a wide read from register 101 falls off the end of the file. A single run therefore covers both the register boundary and the zero upper half.

The bench sweeps all 512 codes against every register count, with and without the vector flag and the three-operand flag. This covers every alignment offset in both rule sets and every constant. A second sweep drives literals of the characteristic sign patterns through all widening modes, with the literal delayed by zero to three cycles.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

   typedef enum logic [2:0] {
      OC_SREG,
      OC_SPEC,
      OC_ICONST,
      OC_FCONST,
      OC_LIT,
      OC_VREG,
      OC_BAD
   } opnd_class_e;

   typedef enum logic {
      ST_IDLE,
      ST_LIT
   } opnd_state_e;

   localparam int          CODE_W      = 9;
   localparam int          WORD_W      = 32;
   localparam int          VIDX_W      = 8;
   localparam int          MAX_SGPR    = 104;

   localparam logic [8:0]  C_VCC_LO    = 9'd106;
   localparam logic [8:0]  C_VCC_HI    = 9'd107;
   localparam logic [8:0]  C_M0        = 9'd124;
   localparam logic [8:0]  C_EXEC_LO   = 9'd126;
   localparam logic [8:0]  C_EXEC_HI   = 9'd127;
   localparam logic [8:0]  C_INT_ZERO  = 9'd128;
   localparam logic [8:0]  C_INT_POS_E = 9'd192;
   localparam logic [8:0]  C_INT_NEG_E = 9'd208;
   localparam logic [8:0]  C_FLT_FIRST = 9'd240;
   localparam logic [8:0]  C_FLT_LAST  = 9'd248;
   localparam logic [8:0]  C_LITERAL   = 9'd255;
   localparam logic [8:0]  C_VREG_BASE = 9'd256;

   localparam logic [31:0] INV2PI_SP   = 32'h3E22_F983;
   localparam logic [63:0] INV2PI_DP   = 64'h3FC4_5F30_6DC9_C882;

endpackage

// File: rtl/opnd_classify.sv
module opnd_classify
   import opnd_pkg::*;
#(
   parameter int NUM_SGPR = 104
) (
   input  logic [8:0]  code,
   input  logic        vop3,
   output opnd_class_e cls
);

   localparam logic [8:0] SGPR_END = 9'(NUM_SGPR);

   always_comb begin
      cls = OC_BAD;
      if (code >= C_VREG_BASE) begin
         cls = vop3 ? OC_VREG : OC_BAD;
      end else if (code < SGPR_END) begin
         cls = OC_SREG;
      end else if (code == C_VCC_LO || code == C_VCC_HI || code == C_M0 ||
                   code == C_EXEC_LO || code == C_EXEC_HI) begin
         cls = OC_SPEC;
      end else if (code >= C_INT_ZERO && code <= C_INT_NEG_E) begin
         cls = OC_ICONST;
      end else if (code >= C_FLT_FIRST && code <= C_FLT_LAST) begin
         cls = OC_FCONST;
      end else if (code == C_LITERAL) begin
         cls = OC_LIT;
      end
   end

endmodule

// File: rtl/opnd_word_sel.sv
module opnd_word_sel
   import opnd_pkg::*;
#(
   parameter int NUM_SGPR = 104
) (
   input  logic [8:0]  code,
   input  logic [31:0] rf_word,
   input  logic [63:0] vcc_val,
   input  logic [63:0] exec_val,
   input  logic [31:0] m0_val,
   output logic [31:0] word
);

   localparam logic [8:0] SGPR_END = 9'(NUM_SGPR);

   always_comb begin
      word = '0;
      if (code < SGPR_END) begin
         word = rf_word;
      end else begin
         unique case (code)
            C_VCC_LO:  word = vcc_val[31:0];
            C_VCC_HI:  word = vcc_val[63:32];
            C_M0:      word = m0_val;
            C_EXEC_LO: word = exec_val[31:0];
            C_EXEC_HI: word = exec_val[63:32];
            default:   word = '0;
         endcase
      end
   end

endmodule

// File: rtl/opnd_const_gen.sv
module opnd_const_gen
   import opnd_pkg::*;
(
   input  logic [8:0]  code,
   input  logic        wide,
   output logic [63:0] value
);

   logic [8:0]  pos_mag;
   logic [8:0]  neg_mag;
   logic [63:0] neg_full;
   logic [7:0]  sp_exp;
   logic [10:0] dp_exp;

   assign pos_mag  = code - C_INT_ZERO;
   assign neg_mag  = code - C_INT_POS_E;
   assign neg_full = 64'd0 - {55'd0, neg_mag};
   // codes 240..247: bit 0 is the sign, bits 2:1 the power of two above 0.5
   assign sp_exp   = 8'd126 + {6'd0, code[2:1]};
   assign dp_exp   = 11'd1022 + {9'd0, code[2:1]};

   always_comb begin
      value = '0;
      if (code <= C_INT_POS_E) begin
         value = {55'd0, pos_mag};
      end else if (code <= C_INT_NEG_E) begin
         value = wide ? neg_full : {32'd0, neg_full[31:0]};
      end else if (code == C_FLT_LAST) begin
         value = wide ? INV2PI_DP : {32'd0, INV2PI_SP};
      end else begin
         value = wide ? {code[0], dp_exp, 52'd0}
                      : {32'd0, code[0], sp_exp, 23'd0};
      end
   end

endmodule

// File: rtl/opnd_align_chk.sv
module opnd_align_chk (
   input  logic [1:0] start_lsb,
   input  logic [1:0] cnt_log2,
   input  logic       vec,
   output logic       misalign
);

   logic [3:0] span_end;

   assign span_end = {2'b00, start_lsb} + (4'd1 << cnt_log2);

   always_comb begin
      if (cnt_log2 == 2'd0) begin
         misalign = 1'b0;
      end else if (vec) begin
         misalign = (span_end > 4'd4);
      end else if (cnt_log2 == 2'd1) begin
         misalign = start_lsb[0];
      end else begin
         misalign = (start_lsb != 2'd0);
      end
   end

endmodule

// File: rtl/opnd_resolve.sv
module opnd_resolve
   import opnd_pkg::*;
#(
   parameter int NUM_SGPR = 104,
   localparam int SGPR_AW = $clog2(NUM_SGPR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [8:0]         in_code,
   input  logic [1:0]         in_cnt,
   input  logic               in_vec,
   input  logic               in_vop3,
   input  logic               in_fp64,
   input  logic               in_signed,
   output logic [SGPR_AW-1:0] rf_addr_lo,
   output logic [SGPR_AW-1:0] rf_addr_hi,
   input  logic [31:0]        rf_data_lo,
   input  logic [31:0]        rf_data_hi,
   input  logic [63:0]        vcc_val,
   input  logic [63:0]        exec_val,
   input  logic [31:0]        m0_val,
   output logic               lit_req,
   input  logic               lit_valid,
   input  logic [31:0]        lit_data,
   output logic               out_valid,
   output logic [63:0]        out_value,
   output logic               out_vreg,
   output logic [7:0]         out_vidx,
   output logic               out_illegal,
   output logic               out_misalign
);

   localparam int NUM_LANES = 2;

   if (NUM_SGPR < 2 || NUM_SGPR > MAX_SGPR) begin : g_bad_sgpr
      $error("opnd_resolve: NUM_SGPR out of range");
   end

   opnd_state_e state;
   opnd_class_e cls;
   logic        accept;
   logic        wide;
   logic        is_reg;
   logic        range_bad;
   logic [63:0] const_val;
   logic [63:0] res_val;
   logic [63:0] lit_wide;

   logic [1:0]  h_cnt;
   logic        h_fp64;
   logic        h_signed;

   logic [8:0]  lane_code [NUM_LANES];
   logic [31:0] lane_rf   [NUM_LANES];
   logic [31:0] lane_word [NUM_LANES];

   assign in_ready = (state == ST_IDLE);
   assign lit_req  = (state == ST_LIT);
   assign accept   = in_valid && in_ready;
   assign wide     = (in_cnt != 2'd0);

   opnd_classify #(.NUM_SGPR(NUM_SGPR)) u_classify (
      .code (in_code),
      .vop3 (in_vop3),
      .cls  (cls)
   );

   assign lane_code[0] = in_code;
   assign lane_code[1] = in_code + 9'd1;
   assign lane_rf[0]   = rf_data_lo;
   assign lane_rf[1]   = rf_data_hi;
   assign rf_addr_lo   = lane_code[0][SGPR_AW-1:0];
   assign rf_addr_hi   = lane_code[1][SGPR_AW-1:0];

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      opnd_word_sel #(.NUM_SGPR(NUM_SGPR)) u_sel (
         .code     (lane_code[g]),
         .rf_word  (lane_rf[g]),
         .vcc_val  (vcc_val),
         .exec_val (exec_val),
         .m0_val   (m0_val),
         .word     (lane_word[g])
      );
   end

   opnd_const_gen u_const (
      .code  (in_code),
      .wide  (wide),
      .value (const_val)
   );

   opnd_align_chk u_align (
      .start_lsb (in_code[1:0]),
      .cnt_log2  (in_cnt),
      .vec       (in_vec),
      .misalign  (range_bad)
   );

   assign is_reg = (cls == OC_SREG) || (cls == OC_SPEC);

   always_comb begin
      unique case (cls)
         OC_SREG, OC_SPEC:     res_val = {wide ? lane_word[1] : 32'd0, lane_word[0]};
         OC_ICONST, OC_FCONST: res_val = const_val;
         default:              res_val = '0;
      endcase
   end

   always_comb begin
      if (h_cnt == 2'd0) begin
         lit_wide = {32'd0, lit_data};
      end else if (h_fp64) begin
         lit_wide = {lit_data, 32'd0};
      end else if (h_signed) begin
         lit_wide = {{32{lit_data[31]}}, lit_data};
      end else begin
         lit_wide = {32'd0, lit_data};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         h_cnt        <= '0;
         h_fp64       <= 1'b0;
         h_signed     <= 1'b0;
         out_valid    <= 1'b0;
         out_value    <= '0;
         out_vreg     <= 1'b0;
         out_vidx     <= '0;
         out_illegal  <= 1'b0;
         out_misalign <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (state == ST_LIT) begin
            if (lit_valid) begin
               state        <= ST_IDLE;
               out_valid    <= 1'b1;
               out_value    <= lit_wide;
               out_vreg     <= 1'b0;
               out_vidx     <= '0;
               out_illegal  <= 1'b0;
               out_misalign <= 1'b0;
            end
         end else if (accept) begin
            if (cls == OC_LIT) begin
               state    <= ST_LIT;
               h_cnt    <= in_cnt;
               h_fp64   <= in_fp64;
               h_signed <= in_signed;
            end else begin
               out_valid    <= 1'b1;
               out_value    <= res_val;
               out_vreg     <= (cls == OC_VREG);
               out_vidx     <= in_code[7:0];
               out_illegal  <= (cls == OC_BAD);
               out_misalign <= is_reg && range_bad;
            end
         end
      end
   end

endmodule

// File: rtl/opnd_resolve_chk.sv
module opnd_resolve_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic [8:0]  in_code,
   input logic        lit_req,
   input logic        lit_valid,
   input logic        out_valid,
   input logic [63:0] out_value,
   input logic        out_vreg,
   input logic        out_illegal,
   input logic        out_misalign
);

   // R5
   lit_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lit_req |-> !in_ready);

   // R5
   lit_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_code == 9'd255) |=> lit_req);

   // R5
   lit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lit_req && !lit_valid) |=> (lit_req && !out_valid));

   // R5
   lit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lit_req && lit_valid) |=> (out_valid && !lit_req));

   // R11
   direct_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_code != 9'd255) |=> out_valid);

   // R11
   no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(in_valid && in_ready) && !(lit_req && lit_valid)) |=> !out_valid);

   // R10
   illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_illegal) |-> (out_value == 64'd0));

   // R9
   vreg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_vreg) |-> (out_value == 64'd0));

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot0({out_illegal, out_vreg, out_misalign}));

endmodule

bind opnd_resolve opnd_resolve_chk i_opnd_resolve_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_code      (in_code),
   .lit_req      (lit_req),
   .lit_valid    (lit_valid),
   .out_valid    (out_valid),
   .out_value    (out_value),
   .out_vreg     (out_vreg),
   .out_illegal  (out_illegal),
   .out_misalign (out_misalign)
);

// File: tb/test_opnd_resolve.sv
`timescale 1ns/1ps
module test_opnd_resolve;

   localparam int NSG = 102;
   localparam int AW  = $clog2(NSG);

   localparam logic [63:0] VCC_V  = 64'h1357_9BDF_2468_ACE0;
   localparam logic [63:0] EXEC_V = 64'hFEDC_BA98_0F1E_2D3C;
   localparam logic [31:0] M0_V   = 32'h0042_BEEF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [8:0]    in_code = '0;
   logic [1:0]    in_cnt = '0;
   logic          in_vec = 1'b0;
   logic          in_vop3 = 1'b0;
   logic          in_fp64 = 1'b0;
   logic          in_signed = 1'b0;
   logic [AW-1:0] rf_addr_lo, rf_addr_hi;
   logic [31:0]   rf_data_lo, rf_data_hi;
   logic          lit_req;
   logic          lit_valid = 1'b0;
   logic [31:0]   lit_data = '0;
   logic          out_valid;
   logic [63:0]   out_value;
   logic          out_vreg;
   logic [7:0]    out_vidx;
   logic          out_illegal;
   logic          out_misalign;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   function automatic logic [31:0] rf_word(input logic [6:0] a);
      return {8'hC3, 1'b0, a, 8'h5A ^ {1'b0, a}, 8'(a) + 8'd17};
   endfunction

   assign rf_data_lo = rf_word(7'(rf_addr_lo));
   assign rf_data_hi = rf_word(7'(rf_addr_hi));

   opnd_resolve #(.NUM_SGPR(NSG)) i_opnd_resolve (
      .clk, .rst_n, .in_valid, .in_ready, .in_code, .in_cnt, .in_vec,
      .in_vop3, .in_fp64, .in_signed, .rf_addr_lo, .rf_addr_hi,
      .rf_data_lo, .rf_data_hi, .vcc_val(VCC_V), .exec_val(EXEC_V),
      .m0_val(M0_V), .lit_req, .lit_valid, .lit_data, .out_valid,
      .out_value, .out_vreg, .out_vidx, .out_illegal, .out_misalign
   );

   task automatic check(input string req, input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit is_special(input int c);
      return c == 106 || c == 107 || c == 124 || c == 126 || c == 127;
   endfunction

   function automatic logic [31:0] ref_word(input int c);
      if (c < NSG) return rf_word(7'(c));
      case (c)
         106: return VCC_V[31:0];
         107: return VCC_V[63:32];
         124: return M0_V;
         126: return EXEC_V[31:0];
         127: return EXEC_V[63:32];
         default: return 32'd0;
      endcase
   endfunction

   function automatic string req_of(input int c);
      if (c >= 256) return "R9";
      if (c < NSG) return "R1";
      if (is_special(c)) return "R2";
      if (c >= 128 && c <= 208) return "R3";
      if (c >= 240 && c <= 248) return "R4";
      if (c == 255) return "R6";
      return "R10";
   endfunction

   task automatic expect_op(input int c, input int cnt, input bit vec,
                            input bit vop3, input bit fp64, input bit sgn,
                            input logic [31:0] lit, output logic [63:0] ev,
                            output bit eill, output bit emis, output bit evr);
      bit          wide = (cnt > 0);
      int          n = 1 << cnt;
      logic [63:0] negv;
      ev = '0; eill = 0; emis = 0; evr = 0;
      if (c >= 256) begin
         if (vop3) evr = 1; else eill = 1;
      end else if (c < NSG || is_special(c)) begin
         ev = {wide ? ref_word(c + 1) : 32'd0, ref_word(c)};
         if (vec) emis = ((c % 4) + n) > 4;
         else if (n == 2) emis = (c % 2) != 0;
         else if (n >= 4) emis = (c % 4) != 0;
      end else if (c >= 128 && c <= 192) begin
         ev = 64'(c - 128);
      end else if (c >= 193 && c <= 208) begin
         negv = 64'd0 - 64'(c - 192);
         ev = wide ? negv : {32'd0, negv[31:0]};
      end else if (c >= 240 && c <= 248) begin
         case (c)
            240: ev = wide ? 64'h3FE0_0000_0000_0000 : 64'h3F00_0000;
            241: ev = wide ? 64'hBFE0_0000_0000_0000 : 64'hBF00_0000;
            242: ev = wide ? 64'h3FF0_0000_0000_0000 : 64'h3F80_0000;
            243: ev = wide ? 64'hBFF0_0000_0000_0000 : 64'hBF80_0000;
            244: ev = wide ? 64'h4000_0000_0000_0000 : 64'h4000_0000;
            245: ev = wide ? 64'hC000_0000_0000_0000 : 64'hC000_0000;
            246: ev = wide ? 64'h4010_0000_0000_0000 : 64'h4080_0000;
            247: ev = wide ? 64'hC010_0000_0000_0000 : 64'hC080_0000;
            default: ev = wide ? 64'h3FC4_5F30_6DC9_C882 : 64'h3E22_F983;
         endcase
      end else if (c == 255) begin
         if (!wide) ev = {32'd0, lit};
         else if (fp64) ev = {lit, 32'd0};
         else if (sgn) ev = {{32{lit[31]}}, lit};
         else ev = {32'd0, lit};
      end else begin
         eill = 1;
      end
   endtask

   task automatic run_op(input int c, input int cnt, input bit vec,
                         input bit vop3, input bit fp64, input bit sgn,
                         input logic [31:0] lit, input int lit_delay);
      logic [63:0] ev;
      bit eill, emis, evr;
      string rq = req_of(c);
      expect_op(c, cnt, vec, vop3, fp64, sgn, lit, ev, eill, emis, evr);
      @(negedge clk);
      check("R11", in_ready === 1'b1, "ready when idle", 64'(in_ready), 64'd1);
      in_valid = 1'b1; in_code = 9'(c); in_cnt = 2'(cnt); in_vec = vec;
      in_vop3 = vop3; in_fp64 = fp64; in_signed = sgn;
      @(negedge clk);
      in_valid = 1'b0;
      if (c == 255) begin
         for (int k = 0; k < lit_delay; k++) begin
            check("R5", lit_req === 1'b1 && in_ready === 1'b0 && out_valid === 1'b0,
                  "literal wait", {61'd0, lit_req, in_ready, out_valid}, 64'd4);
            @(negedge clk);
         end
         check("R5", lit_req === 1'b1, "literal request", 64'(lit_req), 64'd1);
         lit_valid = 1'b1; lit_data = lit;
         @(negedge clk);
         lit_valid = 1'b0;
      end
      check((c == 255) ? "R5" : "R11", out_valid === 1'b1, "out_valid",
            64'(out_valid), 64'd1);
      check(rq, out_value === ev, $sformatf("value code %0d cnt %0d", c, cnt),
            out_value, ev);
      check(rq, out_illegal === eill && out_vreg === evr,
            $sformatf("illegal/vreg code %0d", c),
            {62'd0, out_illegal, out_vreg}, {62'd0, eill, evr});
      check(vec ? "R8" : "R7", out_misalign === emis,
            $sformatf("misalign code %0d cnt %0d", c, cnt),
            64'(out_misalign), 64'(emis));
      if (evr)
         check("R9", out_vidx === 8'(c), "vreg index", 64'(out_vidx), 64'(8'(c)));
      @(negedge clk);
      check("R11", out_valid === 1'b0, "single-cycle output", 64'(out_valid), 64'd0);
   endtask

   logic [31:0] lits [5] = '{32'h8000_0001, 32'h7FFF_FFFF, 32'h0000_0000,
                             32'hFFFF_FFFF, 32'h1234_5678};

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11", out_valid === 1'b0 && in_ready === 1'b1 && lit_req === 1'b0,
            "reset state", {61'd0, out_valid, in_ready, lit_req}, 64'd2);
      rst_n = 1'b1;
      for (int c = 0; c < 512; c++)
         for (int cnt = 0; cnt < 4; cnt++)
            for (int v = 0; v < 2; v++)
               for (int p = 0; p < 2; p++)
                  run_op(c, cnt, v[0], p[0], 1'b0, p[0], 32'hA5C3_0F81, 0);
      for (int i = 0; i < 5; i++)
         for (int cnt = 0; cnt < 4; cnt++)
            for (int m = 0; m < 4; m++)
               for (int d = 0; d < 4; d++)
                  run_op(255, cnt, 1'b1, 1'b1, m[1], m[0], lits[i], d);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      check("R11", 1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule